// File: doc/BRIEF.md
# Downward-Growing Hardware Stack Pointer

This unit keeps the stack pointer of a small processor whose data memory is addressed in bytes. It turns four kinds of request into data-memory accesses: saving one register byte, restoring one register byte, saving a 16-bit return address, and restoring one. The stack grows toward lower addresses. A save writes at the current pointer and then moves the pointer down. A restore moves the pointer up first and reads at the new location.

Return addresses move as two bytes over two consecutive cycles. A lane output marks which half of the word is on the bus in each cycle. The lowest addresses of data memory hold memory-mapped I/O registers. A guard refuses any save that would bring the pointer down to the top address of that region or below, and it raises a sticky fault flag. Software sets the pointer through a dedicated load port, which also clears the fault. The memory array sits outside the block.

Top module: `stk_pointer_unit`

## Requirements
- R1: After reset the pointer equals TOP_ADDR (default 0x045F), and fault_o, busy_o and done_o are all 0.
- R2: Op code 1 (byte save) drives a write of push_byte_i at the current pointer in the request cycle. The pointer is one lower after the next edge, and done_o is 1 for the following cycle.
- R3: Op code 2 (byte restore) reads at pointer+1 in the request cycle. After the next edge the pointer has risen by one and pop_byte_o holds the byte that was read.
- R4: Op code 3 (word save) takes two cycles. The first writes push_addr_i[7:0] at the pointer with lane_o=0. The second writes push_addr_i[15:8] at pointer-1 with lane_o=1 and busy_o=1. After that the pointer is two lower.
- R5: Op code 4 (word restore) takes two cycles. The first reads the high byte at pointer+1 with lane_o=1. The second reads the low byte at pointer+2 with lane_o=0 and busy_o=1. After that ret_addr_o holds {high, low} and the pointer is two higher.
- R6: A byte save when the pointer is at most IO_TOP+1, or a word save when it is at most IO_TOP+2 (IO_TOP defaults to 0x0060), performs no write and leaves the pointer unchanged. It sets fault_o, and fault_o stays set. No write is ever issued at or below IO_TOP.
- R7: When busy_o is 0, load_en_i places load_val_i in the pointer on the next edge and clears fault_o. A request made in the same cycle is ignored.
- R8: While busy_o is 1, a new request and load_en_i are both ignored.
- R9: Saves and restores are last-in first-out: bytes return in the reverse order of their saving.
- R10: mem_we_o and mem_re_o are never 1 in the same cycle. Op codes 0 and 5 to 7 cause no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_i | input | 3 | Request code (0 none, 1 byte save, 2 byte restore, 3 word save, 4 word restore) |
| push_byte_i | input | 8 | Register byte to save |
| push_addr_i | input | 16 | Return address to save |
| load_en_i | input | 1 | Load the pointer |
| load_val_i | input | 16 | Value for the pointer load |
| mem_addr_o | output | 16 | Data-memory byte address |
| mem_we_o | output | 1 | Data-memory write enable |
| mem_wdata_o | output | 8 | Data-memory write byte |
| mem_re_o | output | 1 | Data-memory read strobe |
| mem_rdata_i | input | 8 | Data-memory read byte (same-cycle) |
| lane_o | output | 1 | Word half on the bus: 0 low, 1 high |
| busy_o | output | 1 | Second cycle of a word transfer |
| done_o | output | 1 | One-cycle pulse after a completed request |
| pop_byte_o | output | 8 | Last restored register byte |
| ret_addr_o | output | 16 | Last restored return address |
| sp_o | output | 16 | Current stack pointer |
| fault_o | output | 1 | Sticky guard fault |

## Verification
The embedded properties check four things on every cycle: no write lands at or below the I/O boundary, reads and writes never overlap, a refused save leaves the pointer still and the fault set, and a word transfer always occupies exactly one busy follow-on cycle with the expected lane. Only the directed scenarios can show the data itself. That covers the byte order of return addresses in memory and back, last-in first-out recovery across mixed sequences, the exact guard thresholds at 0x0061, 0x0062 and 0x0063, load precedence, and the ignoring of requests during the busy cycle.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int unsigned STK_AW = 16;
  localparam int unsigned STK_DW = 8;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_SAVE_B = 3'd1,
    OP_REST_B = 3'd2,
    OP_SAVE_W = 3'd3,
    OP_REST_W = 3'd4
  } stk_op_e;

  // Pointer plus a small signed step.
  function automatic logic [STK_AW-1:0] stk_move(input logic [STK_AW-1:0] sp,
                                                 input logic signed [2:0] d);
    return sp + {{(STK_AW-3){d[2]}}, d};
  endfunction

  // True when sp - depth would be at or below the limit.
  function automatic logic stk_breach(input logic [STK_AW-1:0] sp,
                                      input logic [STK_AW-1:0] limit,
                                      input logic [1:0] depth);
    logic [STK_AW:0] lhs;
    logic [STK_AW:0] rhs;
    lhs = {1'b0, sp};
    rhs = {1'b0, limit} + {{(STK_AW-1){1'b0}}, depth};
    return lhs <= rhs;
  endfunction

  function automatic logic stk_known(input stk_op_e op);
    return (op == OP_SAVE_B) || (op == OP_REST_B) ||
           (op == OP_SAVE_W) || (op == OP_REST_W);
  endfunction
endpackage

// File: rtl/stk_ptr_reg.sv
module stk_ptr_reg
  import stk_pkg::*;
#(
  parameter logic [STK_AW-1:0] TOP_ADDR = 16'h045F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [STK_AW-1:0] load_val,
  input  logic              step_en,
  input  logic signed [2:0] step,
  output logic [STK_AW-1:0] sp
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sp <= TOP_ADDR;
    else if (load_en) sp <= load_val;
    else if (step_en) sp <= stk_move(sp, step);
  end
endmodule

// File: rtl/stk_guard.sv
module stk_guard
  import stk_pkg::*;
#(
  parameter logic [STK_AW-1:0] IO_TOP = 16'h0060
) (
  input  logic [STK_AW-1:0] sp,
  input  stk_op_e           op,
  output logic              hit
);
  logic hit_byte;
  logic hit_word;

  assign hit_byte = (op == OP_SAVE_B) && stk_breach(sp, IO_TOP, 2'd1);
  assign hit_word = (op == OP_SAVE_W) && stk_breach(sp, IO_TOP, 2'd2);
  assign hit      = hit_byte || hit_word;
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  stk_op_e           op,
  input  logic [STK_AW-1:0] sp,
  input  logic [STK_DW-1:0] save_byte,
  input  logic [STK_AW-1:0] save_word,
  input  logic [STK_DW-1:0] rdata,
  output logic [STK_AW-1:0] addr,
  output logic              we,
  output logic              re,
  output logic [STK_DW-1:0] wdata,
  output logic              lane,
  output logic              busy,
  output logic              done,
  output logic [STK_DW-1:0] rest_byte,
  output logic [STK_AW-1:0] rest_word,
  output logic              step_en,
  output logic signed [2:0] step
);
  typedef enum logic {SQ_IDLE, SQ_TAIL} sq_state_e;

  sq_state_e         state;
  logic              tail_save;
  logic [STK_DW-1:0] hi_keep;

  assign busy = (state == SQ_TAIL);

  always_comb begin
    addr    = sp;
    we      = 1'b0;
    re      = 1'b0;
    wdata   = '0;
    lane    = 1'b0;
    step_en = 1'b0;
    step    = 3'sd0;
    if (state == SQ_TAIL) begin
      step_en = 1'b1;
      if (tail_save) begin
        addr  = stk_move(sp, -3'sd1);
        we    = 1'b1;
        wdata = hi_keep;
        lane  = 1'b1;
        step  = -3'sd2;
      end else begin
        addr = stk_move(sp, 3'sd2);
        re   = 1'b1;
        step = 3'sd2;
      end
    end else if (go) begin
      unique case (op)
        OP_SAVE_B: begin
          we = 1'b1; wdata = save_byte; step_en = 1'b1; step = -3'sd1;
        end
        OP_REST_B: begin
          addr = stk_move(sp, 3'sd1); re = 1'b1; step_en = 1'b1; step = 3'sd1;
        end
        OP_SAVE_W: begin
          we = 1'b1; wdata = save_word[STK_DW-1:0];
        end
        OP_REST_W: begin
          addr = stk_move(sp, 3'sd1); re = 1'b1; lane = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      tail_save <= 1'b0;
      hi_keep   <= '0;
      done      <= 1'b0;
      rest_byte <= '0;
      rest_word <= '0;
    end else begin
      done <= 1'b0;
      if (state == SQ_TAIL) begin
        state <= SQ_IDLE;
        done  <= 1'b1;
        if (!tail_save) rest_word <= {hi_keep, rdata};
      end else if (go) begin
        unique case (op)
          OP_SAVE_B: done <= 1'b1;
          OP_REST_B: begin
            rest_byte <= rdata;
            done      <= 1'b1;
          end
          OP_SAVE_W: begin
            state     <= SQ_TAIL;
            tail_save <= 1'b1;
            hi_keep   <= save_word[STK_AW-1:STK_DW];
          end
          OP_REST_W: begin
            state     <= SQ_TAIL;
            tail_save <= 1'b0;
            hi_keep   <= rdata;
          end
          default: ;
        endcase
      end
    end
  end

  // R5: a word restore always ends with a low-lane read in the tail cycle
  a_r5_tail_lane_low: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op == OP_REST_W && !busy) |=> (busy && re && !lane));
endmodule

// File: rtl/stk_pointer_unit.sv
module stk_pointer_unit
  import stk_pkg::*;
#(
  parameter logic [STK_AW-1:0] TOP_ADDR = 16'h045F,
  parameter logic [STK_AW-1:0] IO_TOP   = 16'h0060
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_i,
  input  logic [STK_DW-1:0] push_byte_i,
  input  logic [STK_AW-1:0] push_addr_i,
  input  logic              load_en_i,
  input  logic [STK_AW-1:0] load_val_i,
  output logic [STK_AW-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [STK_DW-1:0] mem_wdata_o,
  output logic              mem_re_o,
  input  logic [STK_DW-1:0] mem_rdata_i,
  output logic              lane_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [STK_DW-1:0] pop_byte_o,
  output logic [STK_AW-1:0] ret_addr_o,
  output logic [STK_AW-1:0] sp_o,
  output logic              fault_o
);
  stk_op_e           op;
  logic              start;
  logic              guard_hit;
  logic              go;
  logic              reject;
  logic              load_take;
  logic              step_en;
  logic signed [2:0] step;

  assign op        = stk_op_e'(op_i);
  assign start     = !busy_o && !load_en_i && stk_known(op);
  assign go        = start && !guard_hit;
  assign reject    = start && guard_hit;
  assign load_take = load_en_i && !busy_o;

  stk_guard #(.IO_TOP(IO_TOP)) u_guard (
    .sp (sp_o),
    .op (op),
    .hit(guard_hit)
  );

  stk_ptr_reg #(.TOP_ADDR(TOP_ADDR)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_take),
    .load_val(load_val_i),
    .step_en (step_en),
    .step    (step),
    .sp      (sp_o)
  );

  stk_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .op       (op),
    .sp       (sp_o),
    .save_byte(push_byte_i),
    .save_word(push_addr_i),
    .rdata    (mem_rdata_i),
    .addr     (mem_addr_o),
    .we       (mem_we_o),
    .re       (mem_re_o),
    .wdata    (mem_wdata_o),
    .lane     (lane_o),
    .busy     (busy_o),
    .done     (done_o),
    .rest_byte(pop_byte_o),
    .rest_word(ret_addr_o),
    .step_en  (step_en),
    .step     (step)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fault_o <= 1'b0;
    else if (load_take) fault_o <= 1'b0;
    else if (reject)    fault_o <= 1'b1;
  end

  // R2: an accepted byte save lowers the pointer by exactly one
  a_r2_save_byte_step: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op == OP_SAVE_B) |=> (sp_o == $past(sp_o) - 16'd1));

  // R4: a word save is followed by one busy cycle writing the high lane
  a_r4_word_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op == OP_SAVE_W) |=> (busy_o && mem_we_o && lane_o));

  // R6: no write ever reaches the I/O region
  a_r6_write_above_io: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (mem_addr_o > IO_TOP));

  // R6: a refused save freezes the pointer and raises the fault
  a_r6_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (fault_o && sp_o == $past(sp_o)));

  // R8: the busy phase lasts exactly one cycle
  a_r8_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> !busy_o);

  // R10: read and write strobes never overlap
  a_r10_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && mem_re_o));
endmodule

// File: tb/test_stk_pointer_unit.sv
module test_stk_pointer_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic [7:0]  push_byte_i = 8'h00;
  logic [15:0] push_addr_i = 16'h0000;
  logic        load_en_i = 1'b0;
  logic [15:0] load_val_i = 16'h0000;
  logic [15:0] mem_addr_o;
  logic        mem_we_o;
  logic [7:0]  mem_wdata_o;
  logic        mem_re_o;
  logic [7:0]  mem_rdata_i;
  logic        lane_o, busy_o, done_o, fault_o;
  logic [7:0]  pop_byte_o;
  logic [15:0] ret_addr_o, sp_o;

  int checks = 0;
  int failures = 0;
  logic [15:0] exp_sp;
  logic [7:0]  mem [0:1279];

  always #10 clk = ~clk;

  stk_pointer_unit i_stk_pointer_unit (.*);

  always @(posedge clk) if (mem_we_o && mem_addr_o < 16'd1280) mem[mem_addr_o] <= mem_wdata_o;
  always_comb mem_rdata_i = (mem_addr_o < 16'd1280) ? mem[mem_addr_o] : 8'h00;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [7:0] b, input logic [15:0] w,
                       input logic ld, input logic [15:0] lv);
    op_i = op; push_byte_i = b; push_addr_i = w; load_en_i = ld; load_val_i = lv;
  endtask

  task automatic idle_in();
    drive(3'd0, 8'h00, 16'h0000, 1'b0, 16'h0000);
  endtask

  task automatic load_sp(input logic [15:0] v);
    @(negedge clk); drive(3'd0, 8'h00, 16'h0000, 1'b1, v);
    @(negedge clk); idle_in(); #2;
    exp_sp = v;
    chk(sp_o == v, "R7 load value", sp_o, v);
    chk(fault_o == 1'b0, "R7 load clears fault", fault_o, 0);
  endtask

  task automatic save_byte(input logic [7:0] b);
    @(negedge clk); drive(3'd1, b, 16'h0000, 1'b0, 16'h0000); #2;
    chk(mem_we_o && mem_addr_o == exp_sp && mem_wdata_o == b, "R2 write at pointer",
        {mem_we_o, mem_addr_o}, {1'b1, exp_sp});
    @(negedge clk); idle_in(); #2;
    exp_sp = exp_sp - 16'd1;
    chk(sp_o == exp_sp && done_o, "R2 pointer minus one", sp_o, exp_sp);
  endtask

  task automatic rest_byte(input logic [7:0] exp_b);
    @(negedge clk); drive(3'd2, 8'h00, 16'h0000, 1'b0, 16'h0000); #2;
    chk(mem_re_o && !mem_we_o && mem_addr_o == exp_sp + 16'd1, "R3 read at pointer+1",
        mem_addr_o, exp_sp + 16'd1);
    @(negedge clk); idle_in(); #2;
    exp_sp = exp_sp + 16'd1;
    chk(sp_o == exp_sp && done_o, "R3 pointer plus one", sp_o, exp_sp);
    chk(pop_byte_o == exp_b, "R3 R9 restored byte", pop_byte_o, exp_b);
  endtask

  task automatic save_word(input logic [15:0] w);
    @(negedge clk); drive(3'd3, 8'h00, w, 1'b0, 16'h0000); #2;
    chk(mem_we_o && !lane_o && mem_addr_o == exp_sp && mem_wdata_o == w[7:0],
        "R4 low byte first", {mem_addr_o, mem_wdata_o}, {exp_sp, w[7:0]});
    @(negedge clk); idle_in(); #2;
    chk(busy_o && mem_we_o && lane_o && mem_addr_o == exp_sp - 16'd1 && mem_wdata_o == w[15:8],
        "R4 high byte second", {mem_addr_o, mem_wdata_o}, {exp_sp - 16'd1, w[15:8]});
    @(negedge clk); #2;
    exp_sp = exp_sp - 16'd2;
    chk(sp_o == exp_sp && done_o && !busy_o, "R4 pointer minus two", sp_o, exp_sp);
  endtask

  task automatic rest_word(input logic [15:0] exp_w);
    @(negedge clk); drive(3'd4, 8'h00, 16'h0000, 1'b0, 16'h0000); #2;
    chk(mem_re_o && lane_o && mem_addr_o == exp_sp + 16'd1, "R5 high read first",
        mem_addr_o, exp_sp + 16'd1);
    @(negedge clk); idle_in(); #2;
    chk(busy_o && mem_re_o && !lane_o && mem_addr_o == exp_sp + 16'd2, "R5 low read second",
        mem_addr_o, exp_sp + 16'd2);
    @(negedge clk); #2;
    exp_sp = exp_sp + 16'd2;
    chk(sp_o == exp_sp && done_o, "R5 pointer plus two", sp_o, exp_sp);
    chk(ret_addr_o == exp_w, "R5 return address", ret_addr_o, exp_w);
  endtask

  task automatic t_reset();
    chk(sp_o == 16'h045F, "R1 reset pointer", sp_o, 16'h045F);
    chk(!fault_o && !busy_o && !done_o, "R1 reset flags", {fault_o, busy_o, done_o}, 0);
  endtask

  task automatic t_basic();
    save_byte(8'hA5);
    save_word(16'h1234);
    rest_word(16'h1234);
    rest_byte(8'hA5);
  endtask

  task automatic t_lifo();
    save_byte(8'h11); save_byte(8'h22); save_word(16'hBEEF); save_byte(8'h33);
    rest_byte(8'h33); rest_word(16'hBEEF); rest_byte(8'h22); rest_byte(8'h11);
  endtask

  task automatic t_guard();
    load_sp(16'h0062);
    save_byte(8'h5A);
    @(negedge clk); drive(3'd1, 8'h77, 16'h0000, 1'b0, 16'h0000); #2;
    chk(!mem_we_o, "R6 byte save refused", mem_we_o, 0);
    @(negedge clk); idle_in(); #2;
    chk(fault_o && sp_o == 16'h0061 && !done_o, "R6 fault and pointer held", {fault_o, sp_o}, {1'b1, 16'h0061});
    @(negedge clk); #2;
    chk(fault_o, "R6 fault sticky", fault_o, 1);
    load_sp(16'h0063);
    save_word(16'hC0DE);
    load_sp(16'h0062);
    @(negedge clk); drive(3'd3, 8'h00, 16'hFFFF, 1'b0, 16'h0000); #2;
    chk(!mem_we_o, "R6 word save refused", mem_we_o, 0);
    @(negedge clk); idle_in(); #2;
    chk(fault_o && sp_o == 16'h0062 && !busy_o, "R6 word fault", {fault_o, sp_o}, {1'b1, 16'h0062});
  endtask

  task automatic t_load_wins();
    load_sp(16'h0400);
    @(negedge clk); drive(3'd1, 8'h99, 16'h0000, 1'b1, 16'h0300); #2;
    chk(!mem_we_o && !mem_re_o, "R7 request ignored under load", {mem_we_o, mem_re_o}, 0);
    @(negedge clk); idle_in(); #2;
    exp_sp = 16'h0300;
    chk(sp_o == 16'h0300 && !done_o, "R7 load precedence", sp_o, 16'h0300);
  endtask

  task automatic t_busy_ignore();
    @(negedge clk); drive(3'd3, 8'h00, 16'hA1B2, 1'b0, 16'h0000);
    @(negedge clk); drive(3'd1, 8'h44, 16'h0000, 1'b1, 16'h0100); #2;
    chk(busy_o && mem_wdata_o == 8'hA1, "R8 tail unaffected", mem_wdata_o, 8'hA1);
    @(negedge clk); idle_in(); #2;
    exp_sp = exp_sp - 16'd2;
    chk(sp_o == exp_sp, "R8 load ignored while busy", sp_o, exp_sp);
    @(negedge clk); #2;
    chk(sp_o == exp_sp && !done_o, "R8 no extra request", sp_o, exp_sp);
  endtask

  task automatic t_unknown_ops();
    for (int c = 5; c < 8; c++) begin
      @(negedge clk); drive(3'(c), 8'h01, 16'h0101, 1'b0, 16'h0000); #2;
      chk(!mem_we_o && !mem_re_o, "R10 unused code no access", {mem_we_o, mem_re_o}, 0);
    end
    @(negedge clk); idle_in(); #2;
    chk(sp_o == exp_sp && !done_o, "R10 unused code keeps pointer", sp_o, exp_sp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    exp_sp = 16'h045F;
    t_reset();
    t_basic();
    t_lifo();
    t_guard();
    t_load_wins();
    t_busy_ignore();
    t_unknown_ops();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule